// File: doc/BRIEF.md
# Ping-Pong Audio Sample Memory Writer

This block sits between an audio capture front end and a memory write port. Each accepted input carries a left and a right parallel sample. Depending on configuration the block keeps only the left value (mono) or both (stereo). It stores either the full 16 bits of each value or only its upper byte. It can invert the most significant bit to turn two's complement into offset binary, and it orders the two bytes of a 16-bit value as big-endian or little-endian. The resulting bytes are packed into 32-bit words with byte enables. They are written to rising addresses inside the currently active buffer.

Software gives two buffer base addresses and a sample count per buffer. A stereo pair counts as one sample. When the active buffer has received its count of samples, any partly filled word is written out, the buffer's full flag is raised and writing moves to the base of the other buffer. Software clears a full flag with an acknowledge pulse. If writing arrives at a buffer whose flag is still raised, incoming samples are taken and thrown away and an overrun flag is raised. Writing resumes at that buffer's base once it is acknowledged.

Top module: `audio_buf_writer`

## Requirements
- R1: After reset no write is pending, both full flags and the overrun flag are 0, and the first write goes to the base of buffer A.
- R2: In 8-bit mode (cfg_wide=0) only bits 15:8 of each value are stored, one byte per value; in 16-bit mode (cfg_wide=1) all 16 bits are stored as two bytes.
- R3: With cfg_sign=1 the most significant bit of each stored value (bit 15 in 16-bit mode, bit 7 of the byte in 8-bit mode) is inverted; with cfg_sign=0 values are stored unchanged.
- R4: Byte lane k of mem_data (bits 8k+7:8k, enabled by mem_be[k]) holds the byte at address mem_addr+k. With cfg_little=0 a 16-bit value puts bits 15:8 at the lower address; with cfg_little=1 it puts bits 7:0 there.
- R5: In stereo mode (cfg_stereo=1) the left value is stored at the lower address and the right value immediately after it; in mono mode only the left value is stored.
- R6: Consecutive values are packed into one 32-bit word, which is written as soon as its byte lane 3 is filled. mem_be marks exactly the filled lanes.
- R7: Word addresses start at the active base with its low 6 bits forced to zero and rise by 4 for each word; mem_addr bits 1:0 are always zero.
- R8: After size samples (a stereo pair counting as one) the partly filled word is written at once, the active buffer's full flag (full_a or full_b) is set, and the next sample goes to the other buffer's base.
- R9: A one-cycle pulse on full_ack_a or full_ack_b clears the matching full flag.
- R10: While the active buffer's full flag is set, accepted samples cause no write and set overrun, which stays set until an ovr_ack pulse. Once the buffer is acknowledged, writing restarts at its base.
- R11: mem_valid, mem_addr, mem_data and mem_be stay unchanged while mem_ready is 0. smp_ready is 0 while a write is pending and mem_ready is 0.
- R12: While size is zero, smp_ready is 0 and no sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_stereo | input | 1 | 1 stores left and right, 0 stores left only |
| cfg_wide | input | 1 | 1 stores 16-bit values, 0 stores the upper byte |
| cfg_sign | input | 1 | 1 inverts the MSB of each stored value |
| cfg_little | input | 1 | 1 low byte at lower address, 0 high byte first |
| base_a | input | AW | Base address of buffer A (low 6 bits ignored) |
| base_b | input | AW | Base address of buffer B (low 6 bits ignored) |
| size | input | CW | Samples per buffer |
| smp_valid | input | 1 | Input sample present |
| smp_ready | output | 1 | Input sample taken when high with smp_valid |
| smp_left | input | SMP_W | Left parallel sample |
| smp_right | input | SMP_W | Right parallel sample |
| mem_valid | output | 1 | Write request pending |
| mem_ready | input | 1 | Memory takes the write |
| mem_addr | output | AW | Word-aligned write byte address |
| mem_data | output | 32 | Write data, lane k at address mem_addr+k |
| mem_be | output | 4 | Byte enables |
| full_ack_a | input | 1 | Clears full_a |
| full_ack_b | input | 1 | Clears full_b |
| ovr_ack | input | 1 | Clears overrun |
| full_a | output | 1 | Buffer A completed and not acknowledged |
| full_b | output | 1 | Buffer B completed and not acknowledged |
| overrun | output | 1 | Samples were dropped |

## Verification
All four width and channel combinations are driven with values chosen so that their upper and lower bytes differ and their top bits differ. A wrong byte choice, a missing MSB inversion or swapped byte order therefore each show up as a different word. Buffer sizes are picked so that some buffers end on a word boundary and others end with a one- or two-byte partial word, which separates lane-3 flushes from end-of-buffer flushes. A phase with random memory stalls checks the hold rule. A phase that writes into an unacknowledged buffer must produce no writes and raise overrun, and writing must then restart at that buffer's base.

// File: rtl/abw_pkg.sv
package abw_pkg;
   localparam int WORD_BYTES = 4;
   localparam int WORD_W     = 8 * WORD_BYTES;

   typedef struct packed {
      logic stereo;
      logic wide;
      logic sgn;
      logic little;
   } abw_cfg_t;
endpackage

// File: rtl/abw_fmt.sv
module abw_fmt
   import abw_pkg::*;
#(
   parameter int SMP_W = 16
) (
   input  logic [SMP_W-1:0]   left,
   input  logic [SMP_W-1:0]   right,
   input  abw_cfg_t           cfg,
   input  logic [1:0]         lane,
   output logic [WORD_W-1:0]  data,
   output logic [3:0]         be
);
   localparam logic [SMP_W-1:0] TOP_BIT = {1'b1, {(SMP_W-1){1'b0}}};

   logic [1:0][7:0] hi_b;
   logic [1:0][7:0] lo_b;
   logic [1:0][7:0] first_b;
   logic [1:0][7:0] second_b;

   generate
      if (SMP_W < 16) begin : g_bad_w
         $error("abw_fmt: SMP_W must be at least 16");
      end
      for (genvar ch = 0; ch < 2; ch++) begin : g_ch
         logic [SMP_W-1:0] raw;
         logic [SMP_W-1:0] conv;
         assign raw  = (ch == 0) ? left : right;
         assign conv = raw ^ (cfg.sgn ? TOP_BIT : '0);
         assign hi_b[ch] = conv[SMP_W-1 -: 8];
         assign lo_b[ch] = conv[SMP_W-9 -: 8];
         assign first_b[ch]  = cfg.little ? lo_b[ch] : hi_b[ch];
         assign second_b[ch] = cfg.little ? hi_b[ch] : lo_b[ch];
      end
   endgenerate

   logic [WORD_W-1:0] seq;
   logic [3:0]        mask;

   always_comb begin
      seq  = '0;
      mask = 4'b0000;
      unique case ({cfg.stereo, cfg.wide})
         2'b00: begin
            seq  = {24'h0, hi_b[0]};
            mask = 4'b0001;
         end
         2'b10: begin
            seq  = {16'h0, hi_b[1], hi_b[0]};
            mask = 4'b0011;
         end
         2'b01: begin
            seq  = {16'h0, second_b[0], first_b[0]};
            mask = 4'b0011;
         end
         default: begin
            seq  = {second_b[1], first_b[1], second_b[0], first_b[0]};
            mask = 4'b1111;
         end
      endcase
   end

   assign data = seq << {lane, 3'b000};
   assign be   = 4'(mask << lane);
endmodule

// File: rtl/abw_bufctl.sv
module abw_bufctl #(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [CW-1:0] size,
   input  logic [2:0]    nbytes,
   input  logic [1:0]    ack,
   input  logic          ovr_ack,
   output logic          sel,
   output logic          drop,
   output logic          last,
   output logic [AW-1:0] off,
   output logic [1:0]    full,
   output logic          ovr
);
   logic [CW-1:0] cnt;
   logic          done;

   generate
      if (CW < 2 || AW < 8) begin : g_bad_w
         $error("abw_bufctl: CW must be >= 2 and AW >= 8");
      end
   endgenerate

   assign drop = full[sel];
   assign last = (cnt == size - CW'(1));
   assign done = take && !drop && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel  <= 1'b0;
         cnt  <= '0;
         off  <= '0;
         full <= 2'b00;
         ovr  <= 1'b0;
      end else begin
         for (int i = 0; i < 2; i++) begin
            if (done && sel == 1'(i)) full[i] <= 1'b1;
            else if (ack[i])          full[i] <= 1'b0;
         end
         if (take && drop)  ovr <= 1'b1;
         else if (ovr_ack)  ovr <= 1'b0;
         if (take && !drop) begin
            if (last) begin
               sel <= ~sel;
               cnt <= '0;
               off <= '0;
            end else begin
               cnt <= cnt + CW'(1);
               off <= off + AW'(nbytes);
            end
         end
      end
   end

   AST_FULL_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> full[$past(sel)]); // R8
   AST_SWITCH_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (sel != $past(sel)) && (off == '0)); // R8
   AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (take && drop) |=> ovr); // R10
   AST_ACK_CLEARS_A: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[0] && !(done && !sel)) |=> !full[0]); // R9
endmodule

// File: rtl/abw_pack.sv
module abw_pack
   import abw_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              store,
   input  logic              end_buf,
   input  logic [WORD_W-1:0] fdata,
   input  logic [3:0]        fbe,
   input  logic [AW-1:0]     waddr,
   input  logic              mem_ready,
   output logic              mem_valid,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_data,
   output logic [3:0]        mem_be,
   output logic              busy
);
   logic [WORD_W-1:0] acc_data;
   logic [3:0]        acc_be;
   logic [WORD_W-1:0] mrg_data;
   logic [3:0]        mrg_be;
   logic              flush;

   generate
      for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
         assign mrg_data[8*k +: 8] = fbe[k] ? fdata[8*k +: 8] : acc_data[8*k +: 8];
      end
   endgenerate

   assign mrg_be = acc_be | fbe;
   assign flush  = store && (fbe[WORD_BYTES-1] || end_buf);
   assign busy   = mem_valid && !mem_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_data  <= '0;
         acc_be    <= '0;
         mem_valid <= 1'b0;
         mem_addr  <= '0;
         mem_data  <= '0;
         mem_be    <= '0;
      end else begin
         if (mem_valid && mem_ready) mem_valid <= 1'b0;
         if (store) begin
            if (flush) begin
               mem_valid <= 1'b1;
               mem_addr  <= waddr;
               mem_data  <= mrg_data;
               mem_be    <= mrg_be;
               acc_data  <= '0;
               acc_be    <= '0;
            end else begin
               acc_data <= mrg_data;
               acc_be   <= mrg_be;
            end
         end
      end
   end

   AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> mem_valid && $stable(mem_addr)
                                    && $stable(mem_data) && $stable(mem_be)); // R11
   AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr[1:0] == 2'b00)); // R7
   AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_be != 4'b0000)); // R6
endmodule

// File: rtl/audio_buf_writer.sv
module audio_buf_writer
   import abw_pkg::*;
#(
   parameter int AW    = 32,
   parameter int CW    = 16,
   parameter int SMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_stereo,
   input  logic             cfg_wide,
   input  logic             cfg_sign,
   input  logic             cfg_little,
   input  logic [AW-1:0]    base_a,
   input  logic [AW-1:0]    base_b,
   input  logic [CW-1:0]    size,
   input  logic             smp_valid,
   output logic             smp_ready,
   input  logic [SMP_W-1:0] smp_left,
   input  logic [SMP_W-1:0] smp_right,
   output logic             mem_valid,
   input  logic             mem_ready,
   output logic [AW-1:0]    mem_addr,
   output logic [31:0]      mem_data,
   output logic [3:0]       mem_be,
   input  logic             full_ack_a,
   input  logic             full_ack_b,
   input  logic             ovr_ack,
   output logic             full_a,
   output logic             full_b,
   output logic             overrun
);
   localparam logic [AW-1:0] ALIGN_MASK = AW'(63);

   abw_cfg_t          cfg;
   logic              take, busy, sel, drop, last;
   logic [AW-1:0]     off, base_sel, base_al, waddr;
   logic [1:0]        full;
   logic [2:0]        nbytes;
   logic [WORD_W-1:0] fdata;
   logic [3:0]        fbe;

   generate
      if (WORD_W != 32) begin : g_bad_word
         $error("audio_buf_writer: memory word must be 32 bits");
      end
   endgenerate

   assign cfg       = '{stereo: cfg_stereo, wide: cfg_wide, sgn: cfg_sign, little: cfg_little};
   assign nbytes    = 3'(1) << (32'(cfg_stereo) + 32'(cfg_wide));
   assign smp_ready = (size != '0) && !busy;
   assign take      = smp_valid && smp_ready;
   assign base_sel  = sel ? base_b : base_a;
   assign base_al   = base_sel & ~ALIGN_MASK;
   assign waddr     = base_al + {off[AW-1:2], 2'b00};
   assign full_a    = full[0];
   assign full_b    = full[1];

   abw_fmt #(.SMP_W(SMP_W)) u_fmt (
      .left  (smp_left),
      .right (smp_right),
      .cfg   (cfg),
      .lane  (off[1:0]),
      .data  (fdata),
      .be    (fbe)
   );

   abw_bufctl #(.AW(AW), .CW(CW)) u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (take),
      .size    (size),
      .nbytes  (nbytes),
      .ack     ({full_ack_b, full_ack_a}),
      .ovr_ack (ovr_ack),
      .sel     (sel),
      .drop    (drop),
      .last    (last),
      .off     (off),
      .full    (full),
      .ovr     (overrun)
   );

   abw_pack #(.AW(AW)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .store     (take && !drop),
      .end_buf   (last),
      .fdata     (fdata),
      .fbe       (fbe),
      .waddr     (waddr),
      .mem_ready (mem_ready),
      .mem_valid (mem_valid),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .mem_be    (mem_be),
      .busy      (busy)
   );

   AST_ZERO_SIZE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (size == '0) |-> !smp_ready); // R12
   AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (take && drop) |=> !mem_valid); // R10
   AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |-> !smp_ready); // R11
endmodule

// File: tb/audio_buf_writer_bench.sv
`timescale 1ns/1ps
module audio_buf_writer_bench;
   localparam int AW = 32;
   localparam int CW = 16;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0;
   logic cfg_stereo = 0, cfg_wide = 0, cfg_sign = 0, cfg_little = 0;
   logic [AW-1:0] base_a = '0, base_b = '0;
   logic [CW-1:0] size = '0;
   logic smp_valid = 0;
   logic smp_ready;
   logic [15:0] smp_left = '0, smp_right = '0;
   logic mem_valid;
   logic mem_ready = 1'b1;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_data;
   logic [3:0] mem_be;
   logic full_ack_a = 0, full_ack_b = 0, ovr_ack = 0;
   logic full_a, full_b, overrun;

   audio_buf_writer #(.AW(AW), .CW(CW), .SMP_W(16)) u_audio_buf_writer (.*);

   typedef struct packed {
      logic [31:0] a;
      logic [31:0] d;
      logic [3:0]  be;
   } wr_t;

   wr_t   expq[$];
   int    total = 0;
   int    bad = 0;
   string cur_req = "R1";
   bit    stall_en = 0;

   int          m_off = 0, m_cnt = 0;
   bit          m_sel = 0;
   bit          m_full[2] = '{0, 0};
   bit          m_ovr = 0;
   logic [31:0] m_acc = '0;
   logic [3:0]  m_be = '0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] base_of(bit s);
      return (s ? base_b : base_a) & ~32'd63;
   endfunction

   // Expected-write model built from the requirements
   task automatic model_sample(logic [15:0] l, logic [15:0] r);
      logic [7:0] b[4];
      int n = 0;
      int start;
      logic [15:0] v;
      if (m_full[m_sel]) begin
         m_ovr = 1;
         return;
      end
      for (int ch = 0; ch < (cfg_stereo ? 2 : 1); ch++) begin
         v = (ch == 0) ? l : r;
         if (cfg_sign) v[15] = ~v[15];
         if (!cfg_wide) begin
            b[n] = v[15:8]; n++;
         end else if (cfg_little) begin
            b[n] = v[7:0]; b[n+1] = v[15:8]; n += 2;
         end else begin
            b[n] = v[15:8]; b[n+1] = v[7:0]; n += 2;
         end
      end
      start = m_off;
      for (int i = 0; i < n; i++) begin
         m_acc[8*(m_off % 4) +: 8] = b[i];
         m_be[m_off % 4] = 1'b1;
         m_off++;
      end
      if ((m_off % 4) == 0 || m_cnt == int'(size) - 1) begin
         expq.push_back('{a: base_of(m_sel) + 32'(start & ~3), d: m_acc, be: m_be});
         m_acc = '0;
         m_be = '0;
      end
      if (m_cnt == int'(size) - 1) begin
         m_full[m_sel] = 1;
         m_sel = ~m_sel;
         m_off = 0;
         m_cnt = 0;
      end else begin
         m_cnt++;
      end
   endtask

   task automatic send(logic [15:0] l, logic [15:0] r);
      model_sample(l, r);
      @(posedge clk); #1;
      smp_left = l; smp_right = r; smp_valid = 1;
      @(negedge clk);
      while (!smp_ready) @(negedge clk);
      @(posedge clk); #1;
      smp_valid = 0;
   endtask

   task automatic pulse_ack(int which);
      @(posedge clk); #1;
      if (which == 0) full_ack_a = 1;
      else if (which == 1) full_ack_b = 1;
      else ovr_ack = 1;
      @(posedge clk); #1;
      full_ack_a = 0; full_ack_b = 0; ovr_ack = 0;
      if (which == 2) m_ovr = 0;
      else m_full[which] = 0;
   endtask

   task automatic drain();
      for (int i = 0; i < 400 && (expq.size() != 0 || mem_valid); i++) @(negedge clk);
      @(negedge clk);
      chk(cur_req, "queue left", 64'(expq.size()), 64'd0);
   endtask

   task automatic check_flags(string req);
      @(negedge clk);
      chk(req, "full_a", 64'(full_a), 64'(m_full[0]));
      chk(req, "full_b", 64'(full_b), 64'(m_full[1]));
      chk(req, "overrun", 64'(overrun), 64'(m_ovr));
   endtask

   // memory ready driver
   always @(posedge clk) begin
      #1;
      mem_ready <= stall_en ? 1'($urandom % 2) : 1'b1;
   end

   // monitor: pop and compare each completed write
   always @(negedge clk) begin
      if (rst_n && mem_valid && mem_ready) begin
         if (expq.size() == 0) begin
            total++; bad++;
            $display("FAIL %s unexpected write act=%h/%h exp=none", cur_req, mem_addr, mem_data);
         end else begin
            wr_t e;
            e = expq.pop_front();
            chk(cur_req, "addr", 64'(mem_addr), 64'(e.a));
            chk(cur_req, "data", 64'(mem_data), 64'(e.d));
            chk(cur_req, "be", 64'(mem_be), 64'(e.be));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state, R12 zero size blocks input
      chk("R1", "mem_valid", 64'(mem_valid), 64'd0);
      chk("R1", "flags", {61'd0, full_a, full_b, overrun}, 64'd0);
      chk("R12", "smp_ready size0", 64'(smp_ready), 64'd0);

      // mono 16-bit big-endian: R2 R4 R6 R7, unused low base bits on B
      base_a = 32'h1000; base_b = 32'h2045; size = 4;
      cfg_stereo = 0; cfg_wide = 1; cfg_sign = 0; cfg_little = 0;
      cur_req = "R1_R2_R4_R7";
      send(16'h1234, 0); send(16'h8001, 0); send(16'hABCD, 0); send(16'h00FF, 0);
      drain();
      check_flags("R8");
      pulse_ack(0);
      check_flags("R9");

      // stereo 8-bit sign little-endian into B, partial flush: R3 R5 R8
      cfg_stereo = 1; cfg_wide = 0; cfg_sign = 1; cfg_little = 1; size = 3;
      cur_req = "R3_R5_R8";
      send(16'h0000, 16'h7F00); send(16'h8000, 16'hFFFF); send(16'h1234, 16'h5678);
      drain();
      check_flags("R8");

      // mono 8-bit with memory stalls back into A: R6 R11
      cfg_stereo = 0; cfg_sign = 0; size = 5; stall_en = 1;
      cur_req = "R6_R11";
      send(16'h1100, 0); send(16'h2200, 0); send(16'h3300, 0);
      send(16'h4400, 0); send(16'h5500, 0);
      drain();
      stall_en = 0;
      check_flags("R8");

      // B still full: samples dropped, overrun raised
      cur_req = "R10";
      send(16'hDEAD, 16'hBEEF); send(16'hCAFE, 16'hF00D);
      repeat (3) @(negedge clk);
      chk("R10", "no write", 64'(mem_valid), 64'd0);
      chk("R10", "queue", 64'(expq.size()), 64'd0);
      check_flags("R10");
      pulse_ack(2);
      check_flags("R10");
      pulse_ack(1);

      // stereo 16-bit little-endian restarts at B base: R5 R4 R10
      cfg_stereo = 1; cfg_wide = 1; cfg_sign = 0; cfg_little = 1; size = 2;
      cur_req = "R4_R5_R10";
      send(16'h1234, 16'hABCD); send(16'h8000, 16'h0001);
      drain();
      check_flags("R8");
      pulse_ack(0);

      // mono 16-bit sign little-endian, odd count partial word: R3 R8
      cfg_stereo = 0; cfg_sign = 1; size = 3;
      cur_req = "R3_R8";
      send(16'h0102, 0); send(16'hF00F, 0); send(16'h7FFF, 0);
      drain();
      check_flags("R8");

      // R11 input blocked while a write is stalled
      pulse_ack(0); pulse_ack(1);
      cfg_wide = 1; cfg_stereo = 1; size = 4;
      @(posedge clk); #1 mem_ready = 0; stall_en = 0;
      force mem_ready = 1'b0;
      cur_req = "R11";
      model_sample(16'h5A5A, 16'hA5A5);
      smp_left = 16'h5A5A; smp_right = 16'hA5A5; smp_valid = 1;
      @(posedge clk); #1 smp_valid = 0;
      @(negedge clk);
      chk("R11", "mem_valid stalled", 64'(mem_valid), 64'd1);
      chk("R11", "smp_ready stalled", 64'(smp_ready), 64'd0);
      release mem_ready;
      drain();

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule